// File: doc/BRIEF.md
# ADC Scan Trigger Sequencer

This block decides when a multi-channel analog-to-digital scan runs and walks the converter through it. A 32-bit configuration word holds two things for each of 16 analog inputs: the trigger behaviour of that input's trigger line, and whether that channel's results go to the digital comparator. A scan covers every channel set in a channel-inclusion mask. The block visits those channels from lowest to highest index. It issues one start pulse per channel and waits for the converter's done pulse before it moves on.

Each trigger line works in one of two modes. In edge mode, one rising edge gives exactly one full scan. In level mode, scans repeat back to back for as long as the line stays high. When a channel finishes and its compare bit is set, the block sends the result and the channel index to the comparator as a single-cycle strobe. Software-conversion mode, used without the core-select bit, overrides both kinds of configuration bit. While the module enable is high, configuration writes are refused and answered with a bus error.

Top module: `adc_scan_sequencer`

## Requirements
- R1: After reset, the configuration reads 0, and scan_busy, conv_start, cmp_strobe and cfg_err are all 0.
- R2: Bit 16+k of the configuration word is the trigger-mode bit of input k: 0 selects edge mode and 1 selects level mode. Bit k is the compare-enable bit of channel k. A write with enable at 0 takes effect on that clock edge, and cfg_rdata shows it from the next cycle on.
- R3: A write made while enable is 1 leaves the configuration unchanged. cfg_err goes high for exactly the one cycle after that write.
- R4: Take enable at 1 and a non-empty mask. In edge mode, a rising edge on trigger k while the block is idle starts exactly one scan. Holding the line high afterwards starts no further scan.
- R5: A scan raises conv_start for one cycle per included channel, in ascending index order, and conv_ch gives the channel. The next start waits for a conv_done pulse. scan_busy is 1 from the first start until the last done.
- R6: In level mode, the trigger is sampled at the last channel's done. If it is still high, the next scan's first conv_start appears in the following cycle. Scans stop once the line is low at that point.
- R7: A rising edge that arrives while a scan is running is dropped and never produces a later scan.
- R8: The cycle after a channel's done, cmp_strobe pulses for one cycle with that channel in cmp_ch and its result in cmp_data. This happens only if the channel's compare-enable bit is 1.
- R9: While sw_conv_mode is 1 and core_sel is 0, every input behaves as edge mode and no cmp_strobe is raised, whatever the configuration holds.
- R10: With an all-zero mask, a trigger starts nothing and scan_busy stays 0.
- R11: While enable is 0, no trigger starts a scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Module enable; locks the configuration and arms the triggers |
| sw_conv_mode | input | 1 | Software-conversion mode |
| core_sel | input | 1 | Core-select bit; when 0 together with sw_conv_mode=1, the configuration is bypassed |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |
| cfg_err | output | 1 | Bus error pulse for a refused write |
| scan_mask | input | 16 | Channels included in a scan |
| trig_in | input | 16 | Per-input trigger lines |
| conv_start | output | 1 | Conversion start pulse |
| conv_ch | output | 4 | Channel being converted |
| conv_done | input | 1 | Conversion finished pulse |
| conv_data | input | 12 | Conversion result, valid with conv_done |
| scan_busy | output | 1 | A scan is in progress |
| cmp_strobe | output | 1 | Result forwarded to the comparator |
| cmp_ch | output | 4 | Channel of the forwarded result |
| cmp_data | output | 12 | Forwarded result |

## Verification
The assertions assume that conv_done arrives only while the block waits on a channel, meaning at least one cycle after conv_start and never twice for one start. The bench meets this with a converter responder that answers each start with a single done two cycles later. The assertions also assume that scan_mask does not change in the cycle a scan is launched. The stimulus changes the mask and the mode inputs only while the block is idle. It changes trigger lines on falling edges, at any point in a scan, so that dropped edges are exercised.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_WAIT  = 2'd2
  } sq_state_t;
endpackage

// File: rtl/adc_cfg_bank.sv
module adc_cfg_bank #(
  parameter int NUM_IN = 16,
  localparam int CFG_W = 2 * NUM_IN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CFG_W-1:0]  wr_data,
  input  logic              enable,
  input  logic              sw_conv,
  input  logic              core_sel,
  output logic [CFG_W-1:0]  cfg_q,
  output logic              err_q,
  output logic [NUM_IN-1:0] lvl_eff,
  output logic [NUM_IN-1:0] cmp_eff
);
  logic bypass;
  logic write_ok;
  logic write_refused;

  assign bypass        = sw_conv & ~core_sel;
  assign write_ok      = wr_en & ~enable;
  assign write_refused = wr_en & enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (write_ok) cfg_q <= wr_data;
      err_q <= write_refused;
    end
  end

  assign lvl_eff = bypass ? '0 : cfg_q[CFG_W-1:NUM_IN];
  assign cmp_eff = bypass ? '0 : cfg_q[NUM_IN-1:0];

  AST_LOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && enable) |=> $stable(cfg_q)); // R3
  AST_ERR_AFTER_REFUSAL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && enable) |=> err_q); // R3
  AST_ERR_ONLY_REFUSAL: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $past(wr_en && enable)); // R3
endmodule

// File: rtl/adc_trig_detect.sv
module adc_trig_detect #(
  parameter int NUM_IN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [NUM_IN-1:0] trig,
  input  logic [NUM_IN-1:0] lvl_eff,
  output logic              start_req,
  output logic              hold_req
);
  logic [NUM_IN-1:0] trig_q;
  logic [NUM_IN-1:0] rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= '0;
    else        trig_q <= trig;
  end

  assign rise      = trig & ~trig_q;
  assign hold_req  = enable & (|(trig & lvl_eff));
  assign start_req = enable & ((|(rise & ~lvl_eff)) | (|(trig & lvl_eff)));

  AST_NO_REQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !start_req); // R11
endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm
  import adc_seq_pkg::*;
#(
  parameter int NUM_IN = 16,
  parameter int DATA_W = 12,
  localparam int CH_W  = $clog2(NUM_IN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic              hold_req,
  input  logic [NUM_IN-1:0] scan_mask,
  input  logic [NUM_IN-1:0] cmp_eff,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic              conv_start,
  output logic [CH_W-1:0]   conv_ch,
  output logic              scan_busy,
  output logic              cmp_strobe,
  output logic [CH_W-1:0]   cmp_ch,
  output logic [DATA_W-1:0] cmp_data
);
  // Lowest set bit of m at or above index from; top bit flags a hit.
  function automatic logic [CH_W:0] seek(input logic [NUM_IN-1:0] m,
                                         input logic [CH_W:0] from);
    logic [CH_W:0] r;
    r = '0;
    for (int i = NUM_IN - 1; i >= 0; i--) begin
      if (m[i] && (i >= int'(from))) r = {1'b1, CH_W'(i)};
    end
    return r;
  endfunction

  sq_state_t         state;
  logic [NUM_IN-1:0] mask_q;
  logic [CH_W-1:0]   cur_ch;
  logic [CH_W:0]     launch_pick;
  logic [CH_W:0]     next_pick;
  logic              launch_ok;
  logic              next_found;
  logic              ch_finish;
  logic              scan_launch;
  logic              rescan;

  assign launch_pick = seek(scan_mask, '0);
  assign next_pick   = seek(mask_q, {1'b0, cur_ch} + 1'b1);
  assign launch_ok   = launch_pick[CH_W];
  assign next_found  = next_pick[CH_W];
  assign ch_finish   = (state == SQ_WAIT) && conv_done;
  assign scan_launch = (state == SQ_IDLE) && start_req && launch_ok;
  assign rescan      = ch_finish && !next_found && hold_req && launch_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SQ_IDLE;
      mask_q <= '0;
      cur_ch <= '0;
    end else begin
      unique case (state)
        SQ_IDLE: if (scan_launch) begin
          mask_q <= scan_mask;
          cur_ch <= launch_pick[CH_W-1:0];
          state  <= SQ_ISSUE;
        end
        SQ_ISSUE: state <= SQ_WAIT;
        SQ_WAIT: if (conv_done) begin
          if (next_found) begin
            cur_ch <= next_pick[CH_W-1:0];
            state  <= SQ_ISSUE;
          end else if (rescan) begin
            mask_q <= scan_mask;
            cur_ch <= launch_pick[CH_W-1:0];
            state  <= SQ_ISSUE;
          end else begin
            state <= SQ_IDLE;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_strobe <= 1'b0;
      cmp_ch     <= '0;
      cmp_data   <= '0;
    end else begin
      cmp_strobe <= ch_finish & cmp_eff[cur_ch];
      if (ch_finish) begin
        cmp_ch   <= cur_ch;
        cmp_data <= conv_data;
      end
    end
  end

  assign conv_start = (state == SQ_ISSUE);
  assign conv_ch    = cur_ch;
  assign scan_busy  = (state != SQ_IDLE);

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start); // R5
  AST_CH_INCLUDED: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> mask_q[conv_ch]); // R5
  AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_finish && next_found) |=> (conv_start && (conv_ch > $past(conv_ch)))); // R5
  AST_RESCAN_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    rescan |=> conv_start); // R6
  AST_EMPTY_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_busy && (scan_mask == '0)) |=> !scan_busy); // R10
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_strobe |=> !cmp_strobe); // R8
  AST_STROBE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_strobe |-> $past(ch_finish)); // R8
endmodule

// File: rtl/adc_scan_sequencer.sv
module adc_scan_sequencer #(
  parameter int NUM_IN = 16,
  parameter int DATA_W = 12,
  localparam int CH_W  = $clog2(NUM_IN),
  localparam int CFG_W = 2 * NUM_IN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              sw_conv_mode,
  input  logic              core_sel,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  output logic              cfg_err,
  input  logic [NUM_IN-1:0] scan_mask,
  input  logic [NUM_IN-1:0] trig_in,
  output logic              conv_start,
  output logic [CH_W-1:0]   conv_ch,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic              scan_busy,
  output logic              cmp_strobe,
  output logic [CH_W-1:0]   cmp_ch,
  output logic [DATA_W-1:0] cmp_data
);
  logic [NUM_IN-1:0] lvl_eff;
  logic [NUM_IN-1:0] cmp_eff;
  logic              start_req;
  logic              hold_req;

  adc_cfg_bank #(.NUM_IN(NUM_IN)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_data(cfg_wdata),
    .enable(enable), .sw_conv(sw_conv_mode), .core_sel(core_sel),
    .cfg_q(cfg_rdata), .err_q(cfg_err), .lvl_eff(lvl_eff), .cmp_eff(cmp_eff)
  );

  adc_trig_detect #(.NUM_IN(NUM_IN)) u_trig (
    .clk(clk), .rst_n(rst_n), .enable(enable), .trig(trig_in),
    .lvl_eff(lvl_eff), .start_req(start_req), .hold_req(hold_req)
  );

  adc_scan_fsm #(.NUM_IN(NUM_IN), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .hold_req(hold_req),
    .scan_mask(scan_mask), .cmp_eff(cmp_eff), .conv_done(conv_done),
    .conv_data(conv_data), .conv_start(conv_start), .conv_ch(conv_ch),
    .scan_busy(scan_busy), .cmp_strobe(cmp_strobe), .cmp_ch(cmp_ch),
    .cmp_data(cmp_data)
  );

  AST_IDLE_WHILE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_busy && !enable) |=> !scan_busy); // R11
  AST_BYPASS_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_conv_mode && !core_sel && $past(sw_conv_mode && !core_sel)) |-> !cmp_strobe); // R9
endmodule

// File: tb/tb_adc_scan_sequencer.sv
module tb_adc_scan_sequencer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0, sw_conv_mode = 1'b0, core_sel = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        cfg_err;
  logic [15:0] scan_mask = '0, trig_in = '0;
  logic        conv_start, conv_done = 1'b0, scan_busy, cmp_strobe;
  logic [3:0]  conv_ch, cmp_ch;
  logic [11:0] conv_data = '0, cmp_data;

  adc_scan_sequencer dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sw_conv_mode(sw_conv_mode),
    .core_sel(core_sel), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cfg_err(cfg_err), .scan_mask(scan_mask),
    .trig_in(trig_in), .conv_start(conv_start), .conv_ch(conv_ch),
    .conv_done(conv_done), .conv_data(conv_data), .scan_busy(scan_busy),
    .cmp_strobe(cmp_strobe), .cmp_ch(cmp_ch), .cmp_data(cmp_data)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int total = 0, fails = 0, cycles = 0;
  int n_start = 0, n_cmp = 0, n_busy = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Converter responder: one done, two falling edges after the start is seen.
  int pend = -1;
  logic [11:0] sample_ctr = 12'h100;
  always @(negedge clk) begin
    conv_done = 1'b0;
    if (conv_start) pend = 2;
    else if (pend > 0) pend--;
    if (pend == 0) begin
      conv_done = 1'b1;
      sample_ctr = sample_ctr + 12'h013;
      conv_data = sample_ctr;
      pend = -1;
    end
  end

  // Behavioural reference model, stepped on every rising edge.
  int          m_state = 0;   // 0 idle, 1 issuing, 2 waiting
  int          m_q[$];
  logic [31:0] m_cfg = '0;
  logic [15:0] m_tprev = '0;
  bit          m_err = 0, m_cs = 0;
  int          m_cch = 0;
  logic [11:0] m_cdata = '0;

  always @(posedge clk) begin
    logic [15:0] lvl, cen, rise;
    bit by, req, hold;
    int ch;
    if (!rst_n) begin
      m_state = 0; m_q.delete(); m_cfg = '0; m_tprev = '0;
      m_err = 0; m_cs = 0; m_cch = 0; m_cdata = '0;
    end else begin
      by   = sw_conv_mode && !core_sel;
      lvl  = by ? 16'h0 : m_cfg[31:16];
      cen  = by ? 16'h0 : m_cfg[15:0];
      rise = trig_in & ~m_tprev;
      hold = enable && ((trig_in & lvl) != 0);
      req  = enable && (((rise & ~lvl) != 0) || hold);
      m_cs = 0;
      if (m_state == 0) begin
        if (req && scan_mask != 0) begin
          for (int i = 0; i < 16; i++) if (scan_mask[i]) m_q.push_back(i);
          m_state = 1;
        end
      end else if (m_state == 1) begin
        m_state = 2;
      end else if (conv_done) begin
        ch = m_q.pop_front();
        m_cs = cen[ch]; m_cch = ch; m_cdata = conv_data;
        if (m_q.size() > 0) m_state = 1;
        else if (hold && scan_mask != 0) begin
          for (int i = 0; i < 16; i++) if (scan_mask[i]) m_q.push_back(i);
          m_state = 1;
        end else m_state = 0;
      end
      m_err = cfg_we && enable;
      if (cfg_we && !enable) m_cfg = cfg_wdata;
      m_tprev = trig_in;
    end
    #1;
    if (rst_n) begin
      check(conv_start == (m_state == 1), "R5 conv_start", 32'(conv_start), 32'(m_state == 1));
      if (m_state == 1)
        check(conv_ch == 4'(m_q[0]), "R5 conv_ch", 32'(conv_ch), 32'(m_q[0]));
      check(scan_busy == (m_state != 0), "R5 scan_busy", 32'(scan_busy), 32'(m_state != 0));
      check(cmp_strobe == m_cs, "R8 cmp_strobe", 32'(cmp_strobe), 32'(m_cs));
      if (m_cs) begin
        check(cmp_ch == 4'(m_cch), "R8 cmp_ch", 32'(cmp_ch), 32'(m_cch));
        check(cmp_data == m_cdata, "R8 cmp_data", 32'(cmp_data), 32'(m_cdata));
      end
      check(cfg_rdata == m_cfg, "R2 cfg_rdata", cfg_rdata, m_cfg);
      check(cfg_err == m_err, "R3 cfg_err", 32'(cfg_err), 32'(m_err));
      if (conv_start) n_start++;
      if (cmp_strobe) n_cmp++;
      if (scan_busy) n_busy++;
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++; total++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_counts();
    n_start = 0; n_cmp = 0; n_busy = 0;
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1: reset state
    check(cfg_rdata == 32'h0, "R1 cfg after reset", cfg_rdata, 32'h0);
    check(!scan_busy && !conv_start && !cmp_strobe && !cfg_err, "R1 outputs idle",
          {28'h0, scan_busy, conv_start, cmp_strobe, cfg_err}, 32'h0);

    // R2: level mode on input 2 (bit 18), compare on channels 0 and 7
    cfg_we = 1'b1; cfg_wdata = 32'h0004_0081;
    step(1); cfg_we = 1'b0; step(1);
    check(cfg_rdata == 32'h0004_0081, "R2 write readback", cfg_rdata, 32'h0004_0081);

    // R3: locked write
    enable = 1'b1; cfg_we = 1'b1; cfg_wdata = 32'hFFFF_FFFF;
    step(1); cfg_we = 1'b0;
    check(cfg_err == 1'b1, "R3 error pulse", 32'(cfg_err), 32'h1);
    step(1);
    check(cfg_rdata == 32'h0004_0081, "R3 config kept", cfg_rdata, 32'h0004_0081);
    check(cfg_err == 1'b0, "R3 error single cycle", 32'(cfg_err), 32'h0);

    // R4 / R8: edge trigger on input 3, channels 0, 5, 7
    scan_mask = 16'h00A1; clear_counts();
    trig_in[3] = 1'b1; step(40);
    check(n_start == 3, "R4 one scan per edge", 32'(n_start), 32'd3);
    check(n_cmp == 2, "R8 strobes for enabled channels", 32'(n_cmp), 32'd2);
    trig_in[3] = 1'b0; step(3);

    // R7: edges during a running scan are dropped
    clear_counts();
    trig_in[3] = 1'b1; step(3);
    trig_in[3] = 1'b0; trig_in[5] = 1'b1; step(1);
    trig_in[5] = 1'b0; step(1);
    trig_in[3] = 1'b1; step(35);
    check(n_start == 3, "R7 busy edges dropped", 32'(n_start), 32'd3);
    trig_in[3] = 1'b0; step(3);

    // R6: level mode on input 2
    clear_counts();
    trig_in[2] = 1'b1; step(30);
    trig_in[2] = 1'b0; step(40);
    check(n_start >= 6 && (n_start % 3) == 0, "R6 repeated scans", 32'(n_start), 32'd9);
    check(!scan_busy, "R6 scans stop after release", 32'(scan_busy), 32'h0);

    // R9: bypass makes input 2 edge-triggered and suppresses strobes
    sw_conv_mode = 1'b1; core_sel = 1'b0; clear_counts();
    trig_in[2] = 1'b1; step(40);
    check(n_start == 3, "R9 mode bit bypassed", 32'(n_start), 32'd3);
    check(n_cmp == 0, "R9 compare bypassed", 32'(n_cmp), 32'd0);
    trig_in[2] = 1'b0; sw_conv_mode = 1'b0; step(3);

    // R10: empty mask
    scan_mask = 16'h0; clear_counts();
    trig_in[3] = 1'b1; step(20); trig_in[3] = 1'b0; step(2);
    check(n_start == 0 && n_busy == 0, "R10 empty mask idle", 32'(n_start + n_busy), 32'd0);

    // R11: disabled module ignores triggers
    enable = 1'b0; scan_mask = 16'h00A1; clear_counts();
    trig_in[3] = 1'b1; step(20); trig_in[3] = 1'b0; step(2);
    check(n_start == 0 && n_busy == 0, "R11 disabled idle", 32'(n_start + n_busy), 32'd0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule